// File: doc/BRIEF.md
# Dual-Mode Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency-synthesizer loop. It counts the cycles of a selected oscillator input and emits a single-cycle pulse every N counted cycles, which feeds the loop's phase comparator. Each oscillator input arrives as a tick strobe, one per oscillator cycle, already brought into the block's clock domain. Only ticks from the selected input are counted. Clock cycles without a tick do not advance the divider.

Two mode bits choose the band. In the high band a fixed divide-by-2 prescaler sits ahead of a pulse-swallow core. In the mid band the swallow core counts the oscillator directly. The swallow core has a 16/17 dual-modulus stage, a 4-bit swallow counter and a 12-bit main counter, and divides by 16·P + S, where P is bits 15..4 and S is bits 3..0 of the set value. In the low band a plain 12-bit down-counter divides by bits 15..4 of the word. A new divisor word or a new mode takes effect only at a cycle boundary, so no period is ever cut short. An inhibit input stops the divider and restarts it cleanly.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With mode_hi=1 (high band), exactly 2·W hb_tick strobes occur between output pulses, where W is the 16-bit word read as unsigned. W=2014 (0x07DE) gives 4028.
- R2: With mode_hi=0 and mode_mid=1 (mid band), exactly W mb_tick strobes occur between output pulses.
- R3: With mode_hi=0 and mode_mid=0 (low band), exactly M lb_tick strobes occur between output pulses, where M = div_word[15:4]. Bits 3..0 have no effect in this band.
- R4: In the high and mid bands, a word below 272 acts as 272.
- R5: In the low band, an M below 4 acts as 4.
- R6: A word changed during a period does not alter that period. It sets the length of the next period.
- R7: A change of mode bits during a period takes effect at the next output pulse. The current period completes in the old band.
- R8: While inhibit is high no pulse is produced. After release, the first pulse follows exactly one full period of the current setting.
- R9: During reset div_pulse is 0. The first pulse after reset follows exactly one full period.
- R10: Ticks on the inputs of the non-selected bands have no effect on output timing.
- R11: Clock cycles without a tick of the selected input do not advance the divider.
- R12: div_pulse is high for one clock cycle, the cycle right after the edge that takes in the final tick of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_tick | input | 1 | High-band oscillator strobe, one per oscillator cycle |
| mb_tick | input | 1 | Mid-band oscillator strobe |
| lb_tick | input | 1 | Low-band oscillator strobe |
| mode_hi | input | 1 | 1 selects the high band with the prescaler |
| mode_mid | input | 1 | When mode_hi=0: 1 selects the mid band, 0 selects the low band |
| div_word | input | 16 | Divisor set value |
| inhibit | input | 1 | Stops the divider and holds it at the start of a period |
| div_pulse | output | 1 | One-cycle divided output pulse |

## Verification
The assertions assume that a pulse is always preceded by an edge that took in a tick. They also assume that inhibit and reset restart the period, so the band register may change only at a pulse or right after a restart. They rely on the smallest legal period being four ticks, which makes back-to-back pulses impossible. The stimulus keeps mode and word changes on falling clock edges. It restarts the divider through inhibit before each table entry, and it drives the non-selected tick inputs high throughout, so every measured period also tests that they are ignored.

// File: rtl/pulse_swallow_pkg.sv
package pulse_swallow_pkg;

    localparam int WORD_W   = 16;
    localparam int SW_W     = 4;
    localparam int MAIN_W   = WORD_W - SW_W;
    localparam int MOD_BASE = 1 << SW_W;

    // Smallest swallow set value: main count must exceed the largest swallow count.
    localparam logic [WORD_W-1:0] SW_MIN  = WORD_W'(MOD_BASE * (MOD_BASE + 1));
    localparam logic [MAIN_W-1:0] LOW_MIN = MAIN_W'(4);

    typedef enum logic [1:0] {
        BAND_LOW  = 2'd0,
        BAND_MID  = 2'd1,
        BAND_HIGH = 2'd2
    } band_e;

    typedef struct packed {
        logic [MAIN_W-1:0] main_val;
        logic [SW_W-1:0]   swal_val;
    } swallow_cfg_t;

    function automatic band_e decode_band(input logic hi, input logic mid);
        if (hi)       return BAND_HIGH;
        else if (mid) return BAND_MID;
        else          return BAND_LOW;
    endfunction

    function automatic swallow_cfg_t swallow_split(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] v;
        v = (w < SW_MIN) ? SW_MIN : w;
        return swallow_cfg_t'(v);
    endfunction

    function automatic logic [MAIN_W-1:0] low_divisor(input logic [WORD_W-1:0] w);
        logic [MAIN_W-1:0] m;
        m = w[WORD_W-1 -: MAIN_W];
        return (m < LOW_MIN) ? LOW_MIN : m;
    endfunction

endpackage

// File: rtl/div2_prescaler.sv
module div2_prescaler (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick_in,
    output logic tick_out
);
    logic phase;

    // Every second input tick is passed on.
    assign tick_out = tick_in & phase;

    always_ff @(posedge clk) begin
        if (rst || clear)  phase <= 1'b0;
        else if (tick_in)  phase <= ~phase;
    end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
    parameter int SW_W   = 4,
    parameter int MAIN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic              tick,
    input  logic [MAIN_W-1:0] p_val,
    input  logic [SW_W-1:0]   s_val,
    output logic              done
);
    localparam int MOD_W = SW_W + 1;
    localparam logic [MOD_W-1:0]  LAST_LONG  = MOD_W'(1 << SW_W);
    localparam logic [MOD_W-1:0]  LAST_SHORT = MOD_W'((1 << SW_W) - 1);
    localparam logic [MAIN_W-1:0] MAIN_ONE   = MAIN_W'(1);

    logic [MOD_W-1:0]  mod_cnt;
    logic [SW_W-1:0]   sw_cnt;
    logic [MAIN_W-1:0] main_cnt;
    logic              mod_last;

    // Modulus is 17 while swallow count remains, 16 afterwards.
    assign mod_last = (mod_cnt == ((sw_cnt != '0) ? LAST_LONG : LAST_SHORT));
    assign done     = tick && mod_last && (main_cnt == MAIN_ONE);

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            mod_cnt  <= '0;
            sw_cnt   <= s_val;
            main_cnt <= p_val;
        end else if (tick) begin
            if (!mod_last) begin
                mod_cnt <= mod_cnt + 1'b1;
            end else begin
                mod_cnt <= '0;
                if (main_cnt == MAIN_ONE) begin
                    main_cnt <= p_val;
                    sw_cnt   <= s_val;
                end else begin
                    main_cnt <= main_cnt - 1'b1;
                    if (sw_cnt != '0) sw_cnt <= sw_cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/direct_divider.sv
module direct_divider #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic             tick,
    input  logic [CNT_W-1:0] m_val,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    assign done = tick && (cnt == CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst || reload)  cnt <= m_val;
        else if (tick)      cnt <= done ? m_val : cnt - 1'b1;
    end
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
    import pulse_swallow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hb_tick,
    input  logic              mb_tick,
    input  logic              lb_tick,
    input  logic              mode_hi,
    input  logic              mode_mid,
    input  logic [WORD_W-1:0] div_word,
    input  logic              inhibit,
    output logic              div_pulse
);
    band_e             active_band;
    band_e             next_band;
    swallow_cfg_t      sw_cfg;
    logic [MAIN_W-1:0] low_m;
    logic              restart;
    logic              presc_tick;
    logic              sw_tick, sw_reload, sw_done;
    logic              lo_tick, lo_reload, lo_done;
    logic              done_sel;

    assign next_band = decode_band(mode_hi, mode_mid);
    assign sw_cfg    = swallow_split(div_word);
    assign low_m     = low_divisor(div_word);
    assign restart   = rst | inhibit;

    div2_prescaler u_presc (
        .clk      (clk),
        .rst      (rst),
        .clear    (restart || (active_band != BAND_HIGH)),
        .tick_in  (hb_tick),
        .tick_out (presc_tick)
    );

    always_comb begin
        unique case (active_band)
            BAND_HIGH: sw_tick = presc_tick;
            BAND_MID:  sw_tick = mb_tick;
            default:   sw_tick = 1'b0;
        endcase
    end

    assign sw_reload = restart || (active_band == BAND_LOW);
    assign lo_tick   = (active_band == BAND_LOW) && lb_tick;
    assign lo_reload = restart || (active_band != BAND_LOW);

    swallow_divider #(.SW_W(SW_W), .MAIN_W(MAIN_W)) u_swallow (
        .clk    (clk),
        .rst    (rst),
        .reload (sw_reload),
        .tick   (sw_tick),
        .p_val  (sw_cfg.main_val),
        .s_val  (sw_cfg.swal_val),
        .done   (sw_done)
    );

    direct_divider #(.CNT_W(MAIN_W)) u_direct (
        .clk    (clk),
        .rst    (rst),
        .reload (lo_reload),
        .tick   (lo_tick),
        .m_val  (low_m),
        .done   (lo_done)
    );

    assign done_sel = (active_band == BAND_LOW) ? lo_done : sw_done;

    // Band and divisor are adopted only at restart or at a period boundary.
    always_ff @(posedge clk) begin
        if (restart) begin
            active_band <= next_band;
            div_pulse   <= 1'b0;
        end else begin
            div_pulse <= done_sel;
            if (done_sel) active_band <= next_band;
        end
    end
endmodule

// File: rtl/pulse_swallow_checker.sv
module pulse_swallow_checker
    import pulse_swallow_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  inhibit,
    input logic  hb_tick,
    input logic  mb_tick,
    input logic  lb_tick,
    input logic  div_pulse,
    input band_e active_band
);
    // R8: inhibit blocks the output on the following cycle
    assert_quiet_inhibit_R8: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> !div_pulse);

    // R12: a pulse lasts one cycle
    assert_single_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R11: a pulse needs a tick taken in at the edge that raised it
    assert_pulse_needs_tick_R11: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> $past(hb_tick || mb_tick || lb_tick));

    // R7: band changes only at a boundary or after a restart
    assert_band_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_band) |-> (div_pulse || $past(inhibit) || $past(rst)));
endmodule

bind pulse_swallow_divider pulse_swallow_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .inhibit     (inhibit),
    .hb_tick     (hb_tick),
    .mb_tick     (mb_tick),
    .lb_tick     (lb_tick),
    .div_pulse   (div_pulse),
    .active_band (active_band)
);

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;

    logic        clk = 1'b0;
    logic        rst, hb_tick, mb_tick, lb_tick, mode_hi, mode_mid, inhibit;
    logic [15:0] div_word;
    logic        div_pulse;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pulse_swallow_divider u_pulse_swallow_divider (
        .clk(clk), .rst(rst), .hb_tick(hb_tick), .mb_tick(mb_tick), .lb_tick(lb_tick),
        .mode_hi(mode_hi), .mode_mid(mode_mid), .div_word(div_word),
        .inhibit(inhibit), .div_pulse(div_pulse)
    );

    typedef struct packed {
        logic        hi;
        logic        mid;
        logic [15:0] word;
        logic [31:0] expect_ticks;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t TABLE [NVEC] = '{
        '{1'b1, 1'b0, 16'd300,  32'd600,  4'd1},   // R1
        '{1'b1, 1'b0, 16'd272,  32'd544,  4'd1},   // R1 lower edge
        '{1'b1, 1'b0, 16'd100,  32'd544,  4'd4},   // R4 clamp
        '{1'b0, 1'b1, 16'd1000, 32'd1000, 4'd2},   // R2
        '{1'b0, 1'b1, 16'd273,  32'd273,  4'd2},   // R2
        '{1'b0, 1'b1, 16'd0,    32'd272,  4'd4},   // R4 clamp from zero
        '{1'b0, 1'b1, 16'd271,  32'd272,  4'd4},   // R4 just below
        '{1'b0, 1'b0, 16'h0A20, 32'd162,  4'd3},   // R3
        '{1'b0, 1'b0, 16'h0A2F, 32'd162,  4'd3},   // R3 low nibble ignored
        '{1'b0, 1'b0, 16'h0040, 32'd4,    4'd3},   // R3 minimum
        '{1'b0, 1'b0, 16'h0030, 32'd4,    4'd5},   // R5 clamp
        '{1'b0, 1'b0, 16'h0000, 32'd4,    4'd5}    // R5 clamp from zero
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    // sel: 0 low, 1 mid, 2 high. Non-selected inputs tick every cycle as noise (R10).
    task automatic measure(input int sel, input int exp, input int gap, input int chg_at,
                           input logic c_hi, input logic c_mid, input logic [15:0] c_word,
                           input string tag);
        int consumed = 0;
        int n = 0;
        bit got = 0;
        bit fire;
        bit changed = 0;
        while (!got && n < 20000) begin
            @(negedge clk);
            if (!changed && chg_at >= 0 && consumed == chg_at) begin
                mode_hi = c_hi; mode_mid = c_mid; div_word = c_word; changed = 1;
            end
            fire = ((n % gap) == 0);
            hb_tick = (sel == 2) ? fire : 1'b1;
            mb_tick = (sel == 1) ? fire : 1'b1;
            lb_tick = (sel == 0) ? fire : 1'b1;
            n++;
            @(posedge clk); #1;
            if (fire) consumed++;
            if (div_pulse) begin
                got = 1;
                check(consumed == exp, tag, consumed, exp);
            end
        end
        if (!got) check(1'b0, {tag, " no pulse"}, consumed, exp);
        hb_tick = 0; mb_tick = 0; lb_tick = 0;
    endtask

    task automatic restart();
        @(negedge clk);
        hb_tick = 0; mb_tick = 0; lb_tick = 0;
        inhibit = 1;
        @(negedge clk);
        inhibit = 0;
    endtask

    initial begin
        rst = 1; inhibit = 0; hb_tick = 0; mb_tick = 0; lb_tick = 0;
        mode_hi = 1; mode_mid = 0; div_word = 16'd2014;
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R9 reset output", div_pulse, 0);
        rst = 0;
        measure(2, 4028, 1, -1, 0, 0, 0, "R9 R1 first period 2014 high band");
        measure(2, 4028, 1, -1, 0, 0, 0, "R1 second period 2014 high band");

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            mode_hi = TABLE[i].hi; mode_mid = TABLE[i].mid; div_word = TABLE[i].word;
            restart();
            for (int k = 0; k < 2; k++)
                measure(TABLE[i].hi ? 2 : (TABLE[i].mid ? 1 : 0), int'(TABLE[i].expect_ticks),
                        1, -1, 0, 0, 0, $sformatf("R%0d table entry %0d", TABLE[i].req, i));
        end

        // R6: word change mid-period
        @(negedge clk); mode_hi = 0; mode_mid = 1; div_word = 16'd300;
        restart();
        measure(1, 300, 1, 100, 0, 1, 16'd280, "R6 running period keeps old word");
        measure(1, 280, 1, -1, 0, 0, 0, "R6 next period uses new word");

        // R7: mode change mid-period, high band to low band
        @(negedge clk); mode_hi = 1; mode_mid = 0; div_word = 16'd300;
        restart();
        measure(2, 600, 1, 50, 0, 0, 16'h0050, "R7 running period stays high band");
        measure(0, 5, 1, -1, 0, 0, 0, "R7 next period in low band");

        // R11: gapped ticks
        @(negedge clk); mode_hi = 0; mode_mid = 1; div_word = 16'd280;
        restart();
        measure(1, 280, 3, -1, 0, 0, 0, "R11 gapped ticks");

        // R8: inhibit holds, then a full period follows
        @(negedge clk); mode_hi = 0; mode_mid = 0; div_word = 16'h0080;
        inhibit = 1;
        begin
            int seen = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk); hb_tick = 1; mb_tick = 1; lb_tick = 1;
                @(posedge clk); #1;
                if (div_pulse) seen++;
            end
            check(seen == 0, "R8 pulses during inhibit", seen, 0);
        end
        @(negedge clk); hb_tick = 0; mb_tick = 0; lb_tick = 0; inhibit = 0;
        measure(0, 8, 1, -1, 0, 0, 0, "R8 first period after release");

        // R10: only other-band ticks, then exact period
        begin
            int seen = 0;
            for (int c = 0; c < 50; c++) begin
                @(negedge clk); hb_tick = 1; mb_tick = 1; lb_tick = 0;
                @(posedge clk); #1;
                if (div_pulse) seen++;
            end
            check(seen == 0, "R10 pulses from foreign ticks", seen, 0);
        end
        measure(0, 8, 1, -1, 0, 0, 0, "R10 period unchanged by foreign ticks");

        // R12: pulse width one cycle at minimum divisor
        @(negedge clk); div_word = 16'h0040;
        restart();
        measure(0, 4, 1, -1, 0, 0, 0, "R12 minimum period");
        @(posedge clk); #1;
        check(div_pulse == 1'b0, "R12 pulse width", div_pulse, 0);

        summary();
    end
endmodule